// File: doc/BRIEF.md
# Coprocessor Register-Transfer Primitive Handler

This block lives on the main-processor side of a coprocessor link. It accepts one 16-bit response primitive from the coprocessor. It handles two primitive kinds, and each moves one 32-bit long-word. The general-register kind moves a data or address register to or from the operand channel register. The control-register kind first fetches a select code from the register-select channel register. That code names one of eight control registers, and the block then moves that register to or from the operand channel.

The block holds its own register file: eight data registers, eight address registers and eight control registers. It talks to the channel registers through single-cycle read and write strobes. An illegal select code raises a one-cycle protocol-violation flag. So does a primitive that clears its come-again bit while a conditional-category instruction runs. A finished transfer raises a one-cycle done flag.

Top module: `cp_xfer_handler`

## Requirements
- R1: After reset all strobes and both flags are low and every register reads back as zero.
- R2: Primitive fields are: bit 15 come-again (CA), bit 14 unused, bit 13 direction (DR), bits 12:8 type, bit 3 bank (0 data, 1 address), bits 2:0 register number, bits 7:4 ignored. Type 0x0C is the general-register primitive and type 0x0D is the control-register primitive. Any other type is dropped with no strobe and no flag, and it changes no register.
- R3: A general primitive with DR=0 pulses `opnd_wr_o` in the second cycle after acceptance, with the full 32-bit register value on `opnd_wdata_o`. `done_o` follows in the next cycle.
- R4: A general primitive with DR=1 pulses `opnd_rd_o` in the second cycle after acceptance and loads all 32 bits of `opnd_rdata_i` into the chosen register. `done_o` follows in the next cycle.
- R5: A control primitive pulses `sel_rd_o` once, in the second cycle after acceptance. The operand strobe comes in the third cycle and `done_o` in the fourth.
- R6: The select code's low 12 bits map as 0x000, 0x001, 0x002, 0x800, 0x801, 0x802, 0x803, 0x804 to control registers 0 through 7. Bits 15:12 of the code are ignored.
- R7: Any other select code raises `viol_o` in the third cycle after acceptance. No operand strobe occurs and no register changes.
- R8: CA=0 with `cond_cat_i` high at acceptance raises `viol_o` in the second cycle, with no strobe and no register change, for either primitive kind. CA=0 in the general category proceeds normally.
- R9: `done_o` and `viol_o` are one-cycle pulses and never coincide. At most one of the three channel strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prim_valid_i | input | 1 | Primitive word present; taken when idle |
| prim_i | input | 16 | Response primitive word |
| cond_cat_i | input | 1 | Current instruction is conditional category |
| sel_rd_o | output | 1 | Read strobe to register-select channel register |
| sel_rdata_i | input | 16 | Select code, valid while `sel_rd_o` is high |
| opnd_rd_o | output | 1 | Read strobe to operand channel register |
| opnd_rdata_i | input | 32 | Operand long-word, valid while `opnd_rd_o` is high |
| opnd_wr_o | output | 1 | Write strobe to operand channel register |
| opnd_wdata_o | output | 32 | Operand long-word sent to the channel |
| done_o | output | 1 | Transfer completed |
| viol_o | output | 1 | Protocol violation |

## Verification
The bench builds the block with its default parameters: 32-bit words, type constants 0x0C and 0x0D, and 16-bit select codes. These defaults are small enough to sweep all 16 general registers in both directions. They also allow every one of the 4096 low-12-bit select codes to be tried, each with a varying ignored top nibble, which covers the eight legal codes and every illegal one. Violations caused by bad codes, by CA=0 in the conditional category and by unknown types are followed by read-backs, which show that no register changed.

// File: rtl/cp_xfer_pkg.sv
package cp_xfer_pkg;
  localparam int GEN_IDX_W = 3;
  localparam int CTRL_REGS = 8;
  localparam int GEN_REGS  = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECODE, ST_READ_SEL, ST_TRANSFER, ST_DONE, ST_VIOL
  } state_e;

  typedef enum logic [1:0] {PK_NONE, PK_GEN, PK_CTRL} prim_kind_e;

  typedef struct packed {
    logic                 ca;
    logic                 dr;
    prim_kind_e           kind;
    logic                 da;
    logic [GEN_IDX_W-1:0] num;
  } prim_t;
endpackage

// File: rtl/cp_prim_decode.sv
module cp_prim_decode
  import cp_xfer_pkg::*;
#(
  parameter logic [4:0] TYPE_GEN  = 5'h0C,
  parameter logic [4:0] TYPE_CTRL = 5'h0D
) (
  input  logic [15:0] word_i,
  output prim_t       prim_o
);
  logic unused_bits;
  assign unused_bits = ^{word_i[14], word_i[7:4]};

  always_comb begin
    prim_o.ca  = word_i[15];
    prim_o.dr  = word_i[13];
    prim_o.da  = word_i[3];
    prim_o.num = word_i[GEN_IDX_W-1:0];
    if (word_i[12:8] == TYPE_GEN)       prim_o.kind = PK_GEN;
    else if (word_i[12:8] == TYPE_CTRL) prim_o.kind = PK_CTRL;
    else                                prim_o.kind = PK_NONE;
  end
endmodule

// File: rtl/cp_sel_decode.sv
module cp_sel_decode
  import cp_xfer_pkg::*;
#(
  parameter int IDX_W = $clog2(CTRL_REGS)
) (
  input  logic [11:0]      code_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b1;
    idx_o   = '0;
    unique case (code_i)
      12'h000: idx_o = IDX_W'(0);
      12'h001: idx_o = IDX_W'(1);
      12'h002: idx_o = IDX_W'(2);
      12'h800: idx_o = IDX_W'(3);
      12'h801: idx_o = IDX_W'(4);
      12'h802: idx_o = IDX_W'(5);
      12'h803: idx_o = IDX_W'(6);
      12'h804: idx_o = IDX_W'(7);
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cp_regfile.sv
module cp_regfile #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 24,
  localparam int AW    = $clog2(NREGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[g] <= '0;
      else if (we_i && (addr_i == AW'(g)))          mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = (int'(addr_i) < NREGS) ? mem_q[addr_i] : '0;
endmodule

// File: rtl/cp_xfer_handler.sv
module cp_xfer_handler
  import cp_xfer_pkg::*;
#(
  parameter int         DATA_W    = 32,
  parameter int         SEL_W     = 16,
  parameter logic [4:0] TYPE_GEN  = 5'h0C,
  parameter logic [4:0] TYPE_CTRL = 5'h0D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prim_valid_i,
  input  logic [15:0]       prim_i,
  input  logic              cond_cat_i,
  output logic              sel_rd_o,
  input  logic [SEL_W-1:0]  sel_rdata_i,
  output logic              opnd_rd_o,
  input  logic [DATA_W-1:0] opnd_rdata_i,
  output logic              opnd_wr_o,
  output logic [DATA_W-1:0] opnd_wdata_o,
  output logic              done_o,
  output logic              viol_o
);
  localparam int NREGS  = 2 * GEN_REGS + CTRL_REGS;
  localparam int AW     = $clog2(NREGS);
  localparam int CIDX_W = $clog2(CTRL_REGS);

  state_e              state_q, state_d;
  prim_t               prim_dec, prim_q;
  logic                cond_q;
  logic [CIDX_W-1:0]   cidx_q, sel_idx;
  logic                sel_ok;
  logic [AW-1:0]       rf_addr;
  logic                rf_we;
  logic                unused_sel;

  assign unused_sel = ^sel_rdata_i[SEL_W-1:12];

  cp_prim_decode #(.TYPE_GEN(TYPE_GEN), .TYPE_CTRL(TYPE_CTRL)) u_dec (
    .word_i (prim_i),
    .prim_o (prim_dec)
  );

  cp_sel_decode #(.IDX_W(CIDX_W)) u_sel (
    .code_i  (sel_rdata_i[11:0]),
    .valid_o (sel_ok),
    .idx_o   (sel_idx)
  );

  // general regs occupy 0..15 (bank bit above number), control regs follow
  assign rf_addr = (prim_q.kind == PK_CTRL) ? AW'(2 * GEN_REGS + int'(cidx_q))
                                            : AW'({prim_q.da, prim_q.num});
  assign rf_we   = (state_q == ST_TRANSFER) && prim_q.dr;

  cp_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we),
    .addr_i  (rf_addr),
    .wdata_i (opnd_rdata_i),
    .rdata_o (opnd_wdata_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (prim_valid_i) state_d = ST_DECODE;
      ST_DECODE: begin
        if (prim_q.kind == PK_NONE)          state_d = ST_IDLE;
        else if (cond_q && !prim_q.ca)       state_d = ST_VIOL;
        else if (prim_q.kind == PK_CTRL)     state_d = ST_READ_SEL;
        else                                 state_d = ST_TRANSFER;
      end
      ST_READ_SEL: state_d = sel_ok ? ST_TRANSFER : ST_VIOL;
      ST_TRANSFER: state_d = ST_DONE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      prim_q  <= '0;
      cond_q  <= 1'b0;
      cidx_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && prim_valid_i) begin
        prim_q <= prim_dec;
        cond_q <= cond_cat_i;
      end
      if (state_q == ST_READ_SEL) cidx_q <= sel_idx;
    end
  end

  assign sel_rd_o  = (state_q == ST_READ_SEL);
  assign opnd_wr_o = (state_q == ST_TRANSFER) && !prim_q.dr;
  assign opnd_rd_o = rf_we;
  assign done_o    = (state_q == ST_DONE);
  assign viol_o    = (state_q == ST_VIOL);
endmodule

// File: rtl/cp_xfer_checker.sv
module cp_xfer_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic sel_rd_o,
  input logic opnd_rd_o,
  input logic opnd_wr_o,
  input logic done_o,
  input logic viol_o
);
  a_r9_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && viol_o));
  a_r9_strobes_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel_rd_o, opnd_rd_o, opnd_wr_o}));
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_viol_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> !viol_o);
  a_r3_wr_then_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opnd_wr_o |=> done_o);
  a_r4_rd_then_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opnd_rd_o |=> done_o);
  a_r5_sel_then_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_rd_o |=> (opnd_rd_o || opnd_wr_o || viol_o));
  a_r7_viol_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> !(opnd_rd_o || opnd_wr_o || sel_rd_o));
endmodule

bind cp_xfer_handler cp_xfer_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_rd_o  (sel_rd_o),
  .opnd_rd_o (opnd_rd_o),
  .opnd_wr_o (opnd_wr_o),
  .done_o    (done_o),
  .viol_o    (viol_o)
);

// File: tb/tb_cp_xfer_handler.sv
module tb_cp_xfer_handler;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        prim_valid_i = 1'b0;
  logic [15:0] prim_i = '0;
  logic        cond_cat_i = 1'b0;
  logic        sel_rd_o;
  logic [15:0] sel_rdata_i = '0;
  logic        opnd_rd_o;
  logic [31:0] opnd_rdata_i = '0;
  logic        opnd_wr_o;
  logic [31:0] opnd_wdata_o;
  logic        done_o;
  logic        viol_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int ev_sel, ev_rd, ev_wr, ev_done, ev_viol, ev_n;
  logic [31:0] wr_val;

  always #10 clk_i = ~clk_i;

  cp_xfer_handler dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_gen(bit ca, bit dr, bit da, int num);
    return {ca, 1'b0, dr, 5'h0C, 4'h0, da, 3'(num)};
  endfunction
  function automatic logic [15:0] mk_ctrl(bit ca, bit dr);
    return {ca, 1'b0, dr, 5'h0D, 8'h00};
  endfunction
  function automatic logic [31:0] gv(int i);
    return 32'h9E37_79B9 * 32'(i + 1);
  endfunction
  function automatic logic [31:0] cv(int k);
    return 32'hA5A5_0000 ^ (32'h0101_0101 * 32'(k + 3));
  endfunction
  function automatic int exp_idx(logic [11:0] c);
    case (c)
      12'h000: return 0; 12'h001: return 1; 12'h002: return 2;
      12'h800: return 3; 12'h801: return 4; 12'h802: return 5;
      12'h803: return 6; 12'h804: return 7;
      default: return -1;
    endcase
  endfunction
  function automatic logic [15:0] code_of(int k);
    logic [11:0] t [8] = '{12'h000, 12'h001, 12'h002, 12'h800,
                           12'h801, 12'h802, 12'h803, 12'h804};
    return {4'hF, t[k]};
  endfunction

  // Event window: c counts cycles after the accepting edge
  task automatic run(input logic [15:0] w, input bit cond, input logic [15:0] sel, input logic [31:0] rd);
    ev_sel = 0; ev_rd = 0; ev_wr = 0; ev_done = 0; ev_viol = 0; ev_n = 0; wr_val = '0;
    @(negedge clk_i);
    prim_i = w; prim_valid_i = 1'b1; cond_cat_i = cond;
    sel_rdata_i = sel; opnd_rdata_i = rd;
    for (int c = 1; c <= 6; c++) begin
      @(negedge clk_i);
      prim_valid_i = 1'b0;
      if (sel_rd_o)  begin ev_n++; if (ev_sel == 0)  ev_sel = c;  end
      if (opnd_rd_o) begin ev_n++; if (ev_rd == 0)   ev_rd = c;   end
      if (opnd_wr_o) begin ev_n++; if (ev_wr == 0) begin ev_wr = c; wr_val = opnd_wdata_o; end end
      if (done_o)    begin ev_n++; if (ev_done == 0) ev_done = c; end
      if (viol_o)    begin ev_n++; if (ev_viol == 0) ev_viol = c; end
    end
  endtask

  task automatic read_gen(input bit da, input int num, input logic [31:0] exp, input string req);
    run(mk_gen(1'b1, 1'b0, da, num), 1'b0, '0, '0);
    chk(ev_wr == 2 && ev_done == 3 && ev_n == 2 && wr_val == exp, req, wr_val, exp);
  endtask

  task automatic read_ctrl(input int k, input logic [31:0] exp, input string req);
    run(mk_ctrl(1'b1, 1'b0), 1'b0, code_of(k), '0);
    chk(ev_sel == 2 && ev_wr == 3 && ev_done == 4 && ev_n == 3 && wr_val == exp, req, wr_val, exp);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!sel_rd_o && !opnd_rd_o && !opnd_wr_o && !done_o && !viol_o, "R1 outputs in reset",
        {27'b0, sel_rd_o, opnd_rd_o, opnd_wr_o, done_o, viol_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!sel_rd_o && !opnd_rd_o && !opnd_wr_o && !done_o && !viol_o, "R1 outputs after reset",
        {27'b0, sel_rd_o, opnd_rd_o, opnd_wr_o, done_o, viol_o}, '0);
    read_gen(1'b1, 5, '0, "R1 gen reg zero");
    read_ctrl(7, '0, "R1 ctrl reg zero");

    // R4 load all general registers, R3 read them back
    for (int i = 0; i < 16; i++) begin
      run(mk_gen(1'b1, 1'b1, i[3], i & 7), i[0], '0, gv(i));
      chk(ev_rd == 2 && ev_done == 3 && ev_n == 2, "R4 gen load timing", ev_rd, 2);
    end
    for (int i = 0; i < 16; i++) read_gen(i[3], i & 7, gv(i), "R3 gen readback");

    // R5 load control registers
    for (int k = 0; k < 8; k++) begin
      run(mk_ctrl(1'b1, 1'b1), 1'b1, code_of(k), cv(k));
      chk(ev_sel == 2 && ev_rd == 3 && ev_done == 4 && ev_n == 3, "R5 ctrl load timing", ev_rd, 3);
    end

    // R6/R7 sweep every low-12-bit code with varying ignored top nibble
    for (int i = 0; i < 4096; i++) begin
      logic [15:0] code;
      int e;
      code = {4'(i ^ (i >> 8)), 12'(i)};
      e = exp_idx(12'(i));
      run(mk_ctrl(1'b1, 1'b0), 1'b0, code, '0);
      if (e >= 0)
        chk(ev_sel == 2 && ev_wr == 3 && ev_done == 4 && ev_n == 3 && wr_val == cv(e),
            "R6 select map", wr_val, cv(e));
      else
        chk(ev_sel == 2 && ev_viol == 3 && ev_n == 2, "R7 bad select violation",
            32'(ev_viol), 32'd3);
    end

    // R7 bad codes with DR=1 leave registers intact
    begin
      logic [15:0] bad [4] = '{16'h0003, 16'hA805, 16'h07FF, 16'hFFFF};
      foreach (bad[j]) begin
        run(mk_ctrl(1'b1, 1'b1), 1'b0, bad[j], 32'hDEAD_BEEF);
        chk(ev_viol == 3 && ev_rd == 0 && ev_n == 2, "R7 bad select no load", 32'(ev_rd), 32'd0);
      end
    end
    for (int k = 0; k < 8; k++) read_ctrl(k, cv(k), "R7 ctrl regs unchanged");

    // R8 CA=0 in conditional category
    run(mk_gen(1'b0, 1'b1, 1'b0, 2), 1'b1, '0, 32'h1234_5678);
    chk(ev_viol == 2 && ev_n == 1, "R8 gen CA=0 cond violation", 32'(ev_viol), 32'd2);
    read_gen(1'b0, 2, gv(2), "R8 gen reg unchanged");
    run(mk_ctrl(1'b0, 1'b1), 1'b1, 16'h0801, 32'h1234_5678);
    chk(ev_viol == 2 && ev_sel == 0 && ev_n == 1, "R8 ctrl CA=0 cond violation", 32'(ev_viol), 32'd2);
    read_ctrl(4, cv(4), "R8 ctrl reg unchanged");
    run(mk_gen(1'b0, 1'b0, 1'b1, 6), 1'b0, '0, '0);
    chk(ev_wr == 2 && ev_done == 3 && wr_val == gv(14), "R8 CA=0 general proceeds", wr_val, gv(14));

    // R2 unknown types dropped; ignored bits have no effect
    begin
      logic [4:0] ty [3] = '{5'h00, 5'h1F, 5'h0E};
      foreach (ty[j]) begin
        run({1'b1, 1'b0, 1'b1, ty[j], 8'h01}, 1'b0, 16'h0000, 32'hBAD0_0000);
        chk(ev_n == 0, "R2 unknown type ignored", 32'(ev_n), 32'd0);
      end
    end
    read_gen(1'b0, 1, gv(1), "R2 reg unchanged after unknown type");
    read_ctrl(0, cv(0), "R2 ctrl unchanged after unknown type");
    run({1'b1, 1'b1, 1'b0, 5'h0C, 4'hF, 1'b1, 3'd3}, 1'b1, '0, '0);
    chk(ev_wr == 2 && ev_done == 3 && wr_val == gv(11), "R2 bits 14 and 7:4 ignored", wr_val, gv(11));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule